// File: doc/BRIEF.md
# PCM Minor Frame Synchronizer

This block sits behind a bit synchronizer. It takes the recovered serial data and a one-cycle strobe that marks each valid bit, and finds the boundaries of fixed-length PCM minor frames. It does this by correlating the stream against a sync pattern that is set through configuration inputs. The block moves through three states: hunting, confirming and locked. Once locked it follows the known frame spacing, and it keeps that frame spacing (flywheels) through a few corrupted sync words before it gives up.

While locked, the block does four things:
- It marks the first data bit of each frame with a start-of-frame flag.
- It packs the data bits that follow the sync word into whole words, most significant bit first.
- It numbers each minor frame within its major frame.
- It reports its synchronization state.

The configuration inputs set the sync word length (16 to 33 bits), the pattern, the minor frame length (up to 16,384 bits), the last minor frame index, the mismatch tolerance and the number of consecutive misses that ends lock.

Top module: `pcm_frame_sync`

## Requirements
- R1: During and after reset, `sync_state` is 0 (hunting), `sof` and `word_valid` are low, and `minor_count` is 0.
- R2: Only bits that arrive with `bit_strobe` high are examined. Only the low `cfg_sync_len` bits of `cfg_sync_pattern` are compared, and bit `cfg_sync_len-1` is matched against the earliest received bit. Pattern bits at and above `cfg_sync_len` have no effect.
- R3: In state 0, the window ending at any strobed bit is checked. If it matches within tolerance, the block goes to state 1 (confirming) on the next cycle.
- R4: In state 1, the sync word is tested only at the position exactly `cfg_frame_len` bits after the last accepted sync end. A hit at that position while one earlier hit was already confirmed moves the block to state 2 (locked). A miss at that position returns it to state 0.
- R5: In state 2, each miss at the expected position increments a miss count, and each hit clears it. When the count reaches `cfg_miss_limit`, the block returns to state 0. Misses below that limit keep lock and keep the frame timing.
- R6: In state 2, `sof` rises one cycle after the strobe of the final sync bit of every accepted frame, whether the sync word hit or was flywheeled. It stays high until the cycle after the next strobe.
- R7: In state 2 only, the `cfg_frame_len - cfg_sync_len` bits after the sync word are packed first-bit-to-MSB into `WORD_W`-bit words. `word_valid` pulses for one cycle, on the cycle after the strobe that completes a word.
- R8: `minor_count` is 0 for the frame that enters lock. It advances by one for every accepted frame, returns to 0 after `cfg_minor_last`, and is cleared when lock is lost.
- R9: A window with at most `cfg_err_tol` bit mismatches is a hit. A window with more mismatches is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | Marks a valid recovered bit |
| bit_data | input | 1 | Recovered bit value |
| cfg_sync_len | input | LEN_W | Sync word length, 16 to 33 |
| cfg_sync_pattern | input | SYNC_MAX | Sync pattern, right-justified |
| cfg_err_tol | input | LEN_W | Allowed mismatching bits |
| cfg_frame_len | input | FRAME_W | Minor frame length in bits |
| cfg_minor_last | input | MINOR_W | Index of last minor frame in a major frame |
| cfg_miss_limit | input | MISS_W | Consecutive misses that end lock |
| sof | output | 1 | Start of frame flag |
| word_valid | output | 1 | Word output strobe |
| word_data | output | WORD_W | Packed data word |
| minor_count | output | MINOR_W | Minor frame index |
| sync_state | output | 2 | 0 hunting, 1 confirming, 2 locked |

## Verification
The state, `sof` and `minor_count` change on the cycle after the strobe of a frame's last sync bit. A packed word appears on the cycle after the strobe of its last bit. The bench drives one strobed bit every two clocks from the falling edge, so every result is already registered when the bench samples on the next falling edge. State checks run after a whole frame has been sent. The monitor pops an expected word and minor index on every `word_valid`, and it measures the `sof` width in cycles against the two-cycle strobe spacing.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_CHECK  = 2'd1,
        ST_LOCK   = 2'd2
    } sync_state_e;
endpackage

// File: rtl/pfs_correlator.sv
module pfs_correlator #(
    parameter int SYNC_MAX = 33,
    parameter int LEN_W    = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic                bit_in,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [SYNC_MAX-1:0] cfg_pattern,
    input  logic [LEN_W-1:0]    cfg_tol,
    output logic                hit
);
    logic [SYNC_MAX-2:0] hist_d, hist_q;
    logic [SYNC_MAX-1:0] window;
    logic [LEN_W-1:0]    errs;

    always_comb begin
        window = {hist_q, bit_in};
        errs   = '0;
        for (int i = 0; i < SYNC_MAX; i++) begin
            if (LEN_W'(i) < cfg_len) begin
                errs = errs + LEN_W'(window[i] ^ cfg_pattern[i]);
            end
        end
        hit    = (errs <= cfg_tol);
        hist_d = strobe ? window[SYNC_MAX-2:0] : hist_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // R2
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(hist_q));
endmodule

// File: rtl/pfs_packer.sv
module pfs_packer #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              clear,
    input  logic              bit_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              vld;
        logic [WORD_W-1:0] data;
    } pack_t;

    pack_t r, n;

    always_comb begin
        n     = r;
        n.vld = 1'b0;
        if (clear) begin
            n.cnt = '0;
        end else if (take) begin
            n.sh = {r.sh[WORD_W-2:0], bit_in};
            if (r.cnt == CNT_W'(WORD_W - 1)) begin
                n.cnt  = '0;
                n.vld  = 1'b1;
                n.data = {r.sh[WORD_W-2:0], bit_in};
            end else begin
                n.cnt = r.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= n;
    end

    assign word_valid = r.vld;
    assign word_data  = r.data;

    // R7
    word_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r.vld |-> $past(take));
endmodule

// File: rtl/pcm_frame_sync.sv
module pcm_frame_sync
    import pfs_pkg::*;
#(
    parameter int SYNC_MAX = 33,
    parameter int FRAME_W  = 15,
    parameter int MINOR_W  = 8,
    parameter int WORD_W   = 8,
    parameter int MISS_W   = 3,
    parameter int LEN_W    = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_strobe,
    input  logic                bit_data,
    input  logic [LEN_W-1:0]    cfg_sync_len,
    input  logic [SYNC_MAX-1:0] cfg_sync_pattern,
    input  logic [LEN_W-1:0]    cfg_err_tol,
    input  logic [FRAME_W-1:0]  cfg_frame_len,
    input  logic [MINOR_W-1:0]  cfg_minor_last,
    input  logic [MISS_W-1:0]   cfg_miss_limit,
    output logic                sof,
    output logic                word_valid,
    output logic [WORD_W-1:0]   word_data,
    output logic [MINOR_W-1:0]  minor_count,
    output logic [1:0]          sync_state
);
    typedef struct packed {
        sync_state_e         state;
        logic [FRAME_W-1:0]  pos;
        logic                good;
        logic [MISS_W-1:0]   misses;
        logic [MINOR_W-1:0]  minor;
        logic                sof;
    } fsm_t;

    fsm_t r, n;
    logic hit, at_sync, in_data, pk_take, pk_clear;
    logic [FRAME_W-1:0] data_len;
    logic [MINOR_W-1:0] minor_next;

    pfs_correlator #(.SYNC_MAX(SYNC_MAX), .LEN_W(LEN_W)) u_corr (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (bit_strobe),
        .bit_in      (bit_data),
        .cfg_len     (cfg_sync_len),
        .cfg_pattern (cfg_sync_pattern),
        .cfg_tol     (cfg_err_tol),
        .hit         (hit)
    );

    always_comb begin
        n          = r;
        pk_clear   = 1'b0;
        data_len   = cfg_frame_len - FRAME_W'(cfg_sync_len);
        at_sync    = (r.pos == cfg_frame_len - FRAME_W'(1));
        in_data    = (r.pos < data_len);
        minor_next = (r.minor == cfg_minor_last) ? '0 : r.minor + 1'b1;
        pk_take    = bit_strobe && (r.state == ST_LOCK) && in_data;
        if (bit_strobe) begin
            n.sof = 1'b0;
            n.pos = r.pos + 1'b1;
            case (r.state)
                ST_SEARCH: begin
                    if (hit) begin
                        n.state  = ST_CHECK;
                        n.pos    = '0;
                        n.good   = 1'b0;
                        pk_clear = 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (at_sync) begin
                        n.pos    = '0;
                        pk_clear = 1'b1;
                        if (!hit) begin
                            n.state = ST_SEARCH;
                        end else if (r.good) begin
                            n.state  = ST_LOCK;
                            n.minor  = '0;
                            n.misses = '0;
                            n.sof    = 1'b1;
                        end else begin
                            n.good = 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (at_sync) begin
                        n.pos    = '0;
                        pk_clear = 1'b1;
                        if (hit) begin
                            n.misses = '0;
                            n.minor  = minor_next;
                            n.sof    = 1'b1;
                        end else if (({1'b0, r.misses} + 1'b1) >= {1'b0, cfg_miss_limit}) begin
                            n.state  = ST_SEARCH;
                            n.misses = '0;
                            n.minor  = '0;
                        end else begin
                            n.misses = r.misses + 1'b1;
                            n.minor  = minor_next;
                            n.sof    = 1'b1;
                        end
                    end
                end
                default: n.state = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r.state  <= ST_SEARCH;
            r.pos    <= '0;
            r.good   <= 1'b0;
            r.misses <= '0;
            r.minor  <= '0;
            r.sof    <= 1'b0;
        end else begin
            r <= n;
        end
    end

    pfs_packer #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (pk_take),
        .clear      (pk_clear),
        .bit_in     (bit_data),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    assign sof         = r.sof;
    assign minor_count = r.minor;
    assign sync_state  = r.state;

    // R6
    sof_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r.sof |-> r.state == ST_LOCK);
    // R6
    sof_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r.sof && bit_strobe && !at_sync) |=> !r.sof);
    // R4
    no_skip_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r.state == ST_SEARCH) |=> (r.state != ST_LOCK));
    // R8
    minor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |=> $stable(r.minor));
    // R7
    word_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> r.state == ST_LOCK);
endmodule

// File: tb/pcm_frame_sync_test.sv
module pcm_frame_sync_test;
    localparam logic [15:0] SYNC = 16'hEB90;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, bit_strobe, bit_data;
    logic [5:0]  cfg_sync_len, cfg_err_tol;
    logic [32:0] cfg_sync_pattern;
    logic [14:0] cfg_frame_len;
    logic [7:0]  cfg_minor_last;
    logic [2:0]  cfg_miss_limit;
    logic        sof, word_valid;
    logic [7:0]  word_data, minor_count;
    logic [1:0]  sync_state;

    pcm_frame_sync uut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_data(bit_data),
        .cfg_sync_len(cfg_sync_len), .cfg_sync_pattern(cfg_sync_pattern),
        .cfg_err_tol(cfg_err_tol), .cfg_frame_len(cfg_frame_len),
        .cfg_minor_last(cfg_minor_last), .cfg_miss_limit(cfg_miss_limit),
        .sof(sof), .word_valid(word_valid), .word_data(word_data),
        .minor_count(minor_count), .sync_state(sync_state)
    );

    int checks = 0;
    int fails = 0;
    int sof_seen = 0;
    int sof_exp = 0;
    int sof_width = 0;
    logic sof_prev = 1'b0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b);
        bit_strobe = 1'b1;
        bit_data   = b;
        @(negedge clk);
        bit_strobe = 1'b0;
        @(negedge clk);
    endtask

    // One 64-bit frame: 16-bit sync then six data bytes.
    task automatic send_frame(input logic [15:0] sw, input bit emit, input int k, input int minor);
        logic [7:0] bytes [6];
        for (int i = 0; i < 6; i++) begin
            bytes[i] = emit ? {1'b0, 4'(k), 3'(i)} : 8'h00;
            if (emit) exp_q.push_back({8'(minor), bytes[i]});
        end
        if (emit) sof_exp++;
        for (int b = 15; b >= 0; b--) send_bit(sw[b]);
        for (int i = 0; i < 6; i++)
            for (int b = 7; b >= 0; b--) send_bit(bytes[i][b]);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (word_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7: actual unexpected word %0h expected none", word_data);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check("R7 word", 32'(word_data), 32'(e[7:0]));
                    check("R8 minor", 32'(minor_count), 32'(e[15:8]));
                end
            end
            if (sof) sof_width++;
            if (sof && !sof_prev) sof_seen++;
            if (!sof && sof_prev) begin
                check("R6 sof width", 32'(sof_width), 32'd2);
                sof_width = 0;
            end
            sof_prev = sof;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        rst_n            = 1'b0;
        bit_strobe       = 1'b0;
        bit_data         = 1'b0;
        cfg_sync_len     = 6'd16;
        cfg_sync_pattern = {17'h15A5A, SYNC};   // R2: upper bits garbage
        cfg_err_tol      = 6'd1;
        cfg_frame_len    = 15'd64;
        cfg_minor_last   = 8'd3;
        cfg_miss_limit   = 3'd3;
        repeat (4) @(negedge clk);
        check("R1 state", 32'(sync_state), 32'd0);
        check("R1 sof", 32'(sof), 32'd0);
        check("R1 word_valid", 32'(word_valid), 32'd0);
        check("R1 minor", 32'(minor_count), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) send_bit(1'b0);

        send_frame(SYNC, 0, 0, 0);
        check("R3 hunt to confirm", 32'(sync_state), 32'd1);
        send_frame(SYNC ^ 16'h0100, 0, 1, 0);
        check("R9 one error is a hit", 32'(sync_state), 32'd1);
        send_frame(SYNC, 1, 2, 0);
        check("R4 two hits lock", 32'(sync_state), 32'd2);
        check("R2 upper pattern bits ignored", 32'(sync_state), 32'd2);
        send_frame(SYNC, 1, 3, 1);
        send_frame(SYNC, 1, 4, 2);
        send_frame(SYNC, 1, 5, 3);
        send_frame(SYNC, 1, 6, 0);
        check("R8 wrap", 32'(minor_count), 32'd0);
        send_frame(SYNC ^ 16'h0007, 1, 7, 1);
        check("R5 one miss keeps lock", 32'(sync_state), 32'd2);
        send_frame(SYNC ^ 16'h0007, 1, 8, 2);
        check("R5 two misses keep lock", 32'(sync_state), 32'd2);
        send_frame(SYNC, 1, 9, 3);
        send_frame(SYNC ^ 16'h0007, 1, 10, 0);
        send_frame(SYNC ^ 16'h0007, 1, 11, 1);
        check("R5 hit cleared count", 32'(sync_state), 32'd2);
        send_frame(SYNC ^ 16'h0007, 0, 12, 0);
        check("R9 three errors miss, R5 drop", 32'(sync_state), 32'd0);
        check("R8 cleared on drop", 32'(minor_count), 32'd0);
        send_frame(SYNC, 0, 13, 0);
        check("R3 reacquire", 32'(sync_state), 32'd1);
        send_frame(SYNC ^ 16'h0007, 0, 14, 0);
        check("R4 confirm miss", 32'(sync_state), 32'd0);
        for (int i = 0; i < 20; i++) send_bit(1'b0);
        check("R7 all words seen", 32'(exp_q.size()), 32'd0);
        check("R6 sof count", 32'(sof_seen), 32'(sof_exp));
        report();
    end
endmodule